// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Unit

This block pairs a two-port byte memory with a pair of doorbell flags. Each port has its own active-low chip enable, a read/write select (high means read, low means write), an active-low output enable, an address, write data and registered read data. The two highest addresses of the memory are reserved as mailboxes, one for each direction. They still hold data like any other word, so a sender can leave a message byte there.

When the left port writes the top address, the right port's active-low interrupt asserts. The right port removes it by reading that same address, and it receives the message byte in the same access. The right-to-left direction works the same way through the address one below the top. A write by a port to its own mailbox has no effect on the flags, and neither does a read of the other port's mailbox. If a set and a clear of one flag fall in the same cycle, the set wins, so a new message is never dropped.

Everything is synchronous to one clock with an asynchronous active-low reset. Accesses are sampled at a rising edge, and their effects appear right after that edge.

Top module: `mbx_dualport_irq`

## Requirements
- R1: After reset, `l_irq_n` and `r_irq_n` are both 1 and both read data outputs are 0.
- R2: A left write (`l_ce_n`=0, `l_rw_n`=0) to the top address (all ones, 0x7FF by default) drives `r_irq_n` to 0 after that clock edge.
- R3: A right write to the top address minus one (0x7FE by default) drives `l_irq_n` to 0 after that clock edge.
- R4: A right read (`r_ce_n`=0, `r_oe_n`=0, `r_rw_n`=1) of the top address drives `r_irq_n` back to 1 after that clock edge.
- R5: A left read of the top address minus one drives `l_irq_n` back to 1 after that clock edge.
- R6: No flag is set unless chip enable and read/write are both low in the same cycle as the matching address.
- R7: No flag is cleared unless chip enable and output enable are low and read/write is high in the same cycle as the matching address.
- R8: A port writing its own mailbox address does not set its own flag, and a port reading the other port's mailbox address clears nothing.
- R9: When a set and a clear of the same flag occur in one cycle, the flag ends up asserted (0).
- R10: A write stores its data at the addressed word, mailbox words included. A later read returns the stored byte on that port's read data output one cycle after the read. A read and a write to the same word in one cycle return the old contents.
- R11: A port's read data output holds its value in every cycle without a qualified read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read (1) / write (0) select |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_irq_n | output | 1 | Interrupt to left port, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read (1) / write (0) select |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_irq_n | output | 1 | Interrupt to right port, active low |

## Verification
Each result of this block arrives exactly one rising edge after the access that causes it. That holds for both interrupt flags and for each port's read data. The bench therefore drives an access on a falling edge and lets its reference model step on the following rising edge. It compares all four outputs on the next falling edge, which is one edge of latency with no margin. Because every output is compared in every cycle, the cases where nothing should change (own-mailbox writes, disabled strobes, idle cycles) are checked at the same point as the cases where something changes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Decoded view of one port's access in the current cycle
   typedef struct packed {
      logic wr;      // qualified write
      logic rd;      // qualified read
      logic hit_rx;  // address equals the mailbox this port drains
      logic hit_tx;  // address equals the mailbox this port fills
   } port_dec_t;

   localparam int unsigned NUM_SIDES = 2;
   localparam int unsigned SIDE_L    = 0;
   localparam int unsigned SIDE_R    = 1;

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 11,
   parameter logic [ADDR_W-1:0] RX_ADDR = '1,
   parameter logic [ADDR_W-1:0] TX_ADDR = '1
) (
   input  logic              ce_n,
   input  logic              rw_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   output port_dec_t         dec
);

   generate
      if (RX_ADDR == TX_ADDR) begin : g_bad_map
         $error("mbx_port_dec: receive and send mailboxes must differ");
      end
   endgenerate

   always_comb begin
      dec.wr     = !ce_n && !rw_n;
      dec.rd     = !ce_n && !oe_n && rw_n;
      dec.hit_rx = (addr == RX_ADDR);
      dec.hit_tx = (addr == TX_ADDR);
   end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag_n
);

   logic flag_q;
   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_priority
         always_comb begin
            flag_d = flag_q;
            if (clr) flag_d = 1'b0;
            if (set) flag_d = 1'b1;
         end
      end else begin : g_clr_priority
         always_comb begin
            flag_d = flag_q;
            if (set) flag_d = 1'b1;
            if (clr) flag_d = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag_n = !flag_q;

   generate
      if (SET_WINS) begin : g_chk
         AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (set && clr) |=> !flag_n);  // R9
      end
   endgenerate

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(flag_n));  // R8

endmodule

// File: rtl/mbx_ram.sv
module mbx_ram #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PORTS  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PORTS-1:0]              we,
   input  logic [PORTS-1:0]              re,
   input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
   input  logic [PORTS-1:0][DATA_W-1:0]  wdata,
   output logic [PORTS-1:0][DATA_W-1:0]  rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Lower-numbered port is written last, so it wins an address collision
   always_ff @(posedge clk) begin
      for (int p = PORTS - 1; p >= 0; p--) begin
         if (we[p]) mem[addr[p]] <= wdata[p];
      end
   end

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_rd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata[p] <= '0;
            else if (re[p]) rdata[p] <= mem[addr[p]];
         end

         AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !re[p] |=> $stable(rdata[p]));  // R11
      end
   endgenerate

endmodule

// File: rtl/mbx_dualport_irq.sv
module mbx_dualport_irq
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned DATA_W   = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce_n,
   input  logic              l_rw_n,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_irq_n,
   input  logic              r_ce_n,
   input  logic              r_rw_n,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_irq_n
);

   // Mailbox drained by the right port (filled by left) and vice versa
   localparam logic [ADDR_W-1:0] BOX_TO_R = '1;
   localparam logic [ADDR_W-1:0] BOX_TO_L = BOX_TO_R - 1'b1;

   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("mbx_dualport_irq: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("mbx_dualport_irq: DATA_W must be at least 1");
      end
   endgenerate

   logic      [NUM_SIDES-1:0]             ce_n, rw_n, oe_n;
   logic      [NUM_SIDES-1:0][ADDR_W-1:0] addr;
   logic      [NUM_SIDES-1:0][DATA_W-1:0] wdata, rdata;
   logic      [NUM_SIDES-1:0]             we, re, irq_n;
   port_dec_t [NUM_SIDES-1:0]             dec;

   assign ce_n  = {r_ce_n,  l_ce_n};
   assign rw_n  = {r_rw_n,  l_rw_n};
   assign oe_n  = {r_oe_n,  l_oe_n};
   assign addr  = {r_addr,  l_addr};
   assign wdata = {r_wdata, l_wdata};

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         localparam logic [ADDR_W-1:0] RX = (s == SIDE_L) ? BOX_TO_L : BOX_TO_R;
         localparam logic [ADDR_W-1:0] TX = (s == SIDE_L) ? BOX_TO_R : BOX_TO_L;
         localparam int unsigned       PEER = NUM_SIDES - 1 - s;

         mbx_port_dec #(
            .ADDR_W  (ADDR_W),
            .RX_ADDR (RX),
            .TX_ADDR (TX)
         ) u_dec (
            .ce_n (ce_n[s]),
            .rw_n (rw_n[s]),
            .oe_n (oe_n[s]),
            .addr (addr[s]),
            .dec  (dec[s])
         );

         assign we[s] = dec[s].wr;
         assign re[s] = dec[s].rd;

         mbx_flag #(
            .SET_WINS (SET_WINS)
         ) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (dec[PEER].wr && dec[PEER].hit_tx),
            .clr    (dec[s].rd && dec[s].hit_rx),
            .flag_n (irq_n[s])
         );
      end
   endgenerate

   mbx_ram #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PORTS  (NUM_SIDES)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .re    (re),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   assign l_rdata = rdata[SIDE_L];
   assign r_rdata = rdata[SIDE_R];
   assign l_irq_n = irq_n[SIDE_L];
   assign r_irq_n = irq_n[SIDE_R];

   // Port-level checks
   logic l_fills_r, r_fills_l, r_drains, l_drains, r_self_wr, l_self_wr;
   assign l_fills_r = !l_ce_n && !l_rw_n && (l_addr == BOX_TO_R);
   assign r_fills_l = !r_ce_n && !r_rw_n && (r_addr == BOX_TO_L);
   assign r_drains  = !r_ce_n && !r_oe_n && r_rw_n && (r_addr == BOX_TO_R);
   assign l_drains  = !l_ce_n && !l_oe_n && l_rw_n && (l_addr == BOX_TO_L);
   assign r_self_wr = !r_ce_n && !r_rw_n && (r_addr == BOX_TO_R);
   assign l_self_wr = !l_ce_n && !l_rw_n && (l_addr == BOX_TO_L);

   AST_LEFT_RINGS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      l_fills_r |=> !r_irq_n);  // R2
   AST_RIGHT_RINGS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      r_fills_l |=> !l_irq_n);  // R3
   AST_RIGHT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (r_drains && !l_fills_r) |=> r_irq_n);  // R4
   AST_LEFT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (l_drains && !r_fills_l) |=> l_irq_n);  // R5
   AST_R_NO_SELF_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (r_self_wr && r_irq_n && !l_fills_r) |=> r_irq_n);  // R8
   AST_L_NO_SELF_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (l_self_wr && l_irq_n && !r_fills_l) |=> l_irq_n);  // R8
   AST_R_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_fills_r && !r_drains) |=> $stable(r_irq_n));  // R6
   AST_L_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_fills_l && !l_drains) |=> $stable(l_irq_n));  // R7

endmodule

// File: tb/mbx_dualport_irq_tb.sv
module mbx_dualport_irq_tb;

   localparam int AW = 11;
   localparam int DW = 8;
   localparam logic [AW-1:0] TOP  = 11'h7FF;
   localparam logic [AW-1:0] TOP1 = 11'h7FE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
   logic r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic l_irq_n, r_irq_n;

   always #4 clk = ~clk;

   mbx_dualport_irq u_dut (
      .clk(clk), .rst_n(rst_n),
      .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
      .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
      .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
      .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
   );

   // Reference model state
   logic [DW-1:0] ref_mem [int];
   logic [DW-1:0] exp_lrd = '0, exp_rrd = '0;
   logic exp_lirq = 1'b1, exp_rirq = 1'b1;
   int n_vec = 0, n_bad = 0;
   string tag = "R1";
   bit done = 1'b0;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("l_irq_n", {31'd0, l_irq_n}, {31'd0, exp_lirq});
      chk("r_irq_n", {31'd0, r_irq_n}, {31'd0, exp_rirq});
      chk("l_rdata", {24'd0, l_rdata}, {24'd0, exp_lrd});
      chk("r_rdata", {24'd0, r_rdata}, {24'd0, exp_rrd});
   endtask

   // Model step at a rising edge, from the inputs held since the falling edge
   task automatic model_step();
      bit lwr, rwr, lrd, rrd;
      logic [DW-1:0] lold, rold;
      lwr = !l_ce_n && !l_rw_n;
      rwr = !r_ce_n && !r_rw_n;
      lrd = !l_ce_n && !l_oe_n && l_rw_n;
      rrd = !r_ce_n && !r_oe_n && r_rw_n;
      lold = ref_mem.exists(int'(l_addr)) ? ref_mem[int'(l_addr)] : 'x;
      rold = ref_mem.exists(int'(r_addr)) ? ref_mem[int'(r_addr)] : 'x;
      if (lrd) exp_lrd = lold;
      if (rrd) exp_rrd = rold;
      if (rwr) ref_mem[int'(r_addr)] = r_wdata;
      if (lwr) ref_mem[int'(l_addr)] = l_wdata;
      if (rrd && r_addr == TOP)  exp_rirq = 1'b1;
      if (lwr && l_addr == TOP)  exp_rirq = 1'b0;
      if (lrd && l_addr == TOP1) exp_lirq = 1'b1;
      if (rwr && r_addr == TOP1) exp_lirq = 1'b0;
   endtask

   // One cycle: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic cyc(input logic lce, lrw, loe, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                      input logic rce, rrw, roe, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
      l_ce_n = lce; l_rw_n = lrw; l_oe_n = loe; l_addr = la; l_wdata = ld;
      r_ce_n = rce; r_rw_n = rrw; r_oe_n = roe; r_addr = ra; r_wdata = rd;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   // shorthand encodings: write = ce 0, rw 0; read = ce 0, oe 0, rw 1; idle = ce 1
   task automatic lw(logic [AW-1:0] a, logic [DW-1:0] d); cyc(0,0,1,a,d, 1,1,1,0,0); endtask
   task automatic rw(logic [AW-1:0] a, logic [DW-1:0] d); cyc(1,1,1,0,0, 0,0,1,a,d); endtask
   task automatic lr(logic [AW-1:0] a); cyc(0,1,0,a,0, 1,1,1,0,0); endtask
   task automatic rr(logic [AW-1:0] a); cyc(1,1,1,0,0, 0,1,0,a,0); endtask
   task automatic idle(); cyc(1,1,1,0,0, 1,1,1,0,0); endtask

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1";
      compare_all();
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      tag = "R10";
      cyc(0,0,1,11'h010,8'hA5, 0,0,1,11'h020,8'h3C);
      cyc(0,1,0,11'h020,8'h00, 0,1,0,11'h010,8'h00);
      tag = "R11";
      idle(); idle();

      tag = "R2";
      lw(TOP, 8'h5A);
      tag = "R8";
      lr(TOP);             // left reading right's mailbox: no clear
      lw(TOP1, 8'h11);     // left writing own mailbox: no set
      tag = "R4";
      rr(TOP);             // clears, returns 5A
      tag = "R11";
      idle();

      tag = "R3";
      rw(TOP1, 8'hC3);
      tag = "R8";
      rr(TOP1);
      rw(TOP, 8'h77);
      tag = "R5";
      lr(TOP1);
      idle();

      tag = "R6";
      cyc(1,0,1,TOP,8'hEE, 1,0,1,TOP1,8'hEE); // chip enable high
      cyc(0,1,1,TOP,8'hEE, 0,1,1,TOP1,8'hEE); // rw high, oe high
      lr(TOP); rr(TOP1);                         // mailboxes unchanged by those
      tag = "R7";
      lw(TOP, 8'h42); rw(TOP1, 8'h24);
      cyc(1,1,1,0,0, 0,1,1,TOP,0);           // right oe high
      cyc(1,1,0,0,0, 1,1,0,TOP,0);           // right ce high
      cyc(0,1,1,TOP1,0, 1,1,1,0,0);          // left oe high
      cyc(1,1,0,TOP1,0, 1,1,1,0,0);          // left ce high
      rr(TOP); lr(TOP1);

      tag = "R9";
      lw(TOP, 8'h81);
      cyc(0,0,1,TOP,8'h82, 0,1,0,TOP,0);     // set with clear, already low
      cyc(0,0,1,TOP,8'h83, 0,1,0,TOP,0);
      rr(TOP);
      cyc(0,0,1,TOP,8'h84, 0,1,0,TOP,0);     // set with clear from high
      cyc(0,1,0,TOP1,0, 0,0,1,TOP1,8'h90);   // left side same
      tag = "R2";
      cyc(0,0,1,TOP,8'h91, 0,0,1,TOP1,8'h92); // both directions at once
      tag = "R4";
      cyc(0,1,0,TOP1,0, 0,1,0,TOP,0);          // both drained at once
      tag = "R11";
      idle(); idle();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule